// File: doc/BRIEF.md
# MSI Line Coherence Controller

This block is the coherence engine for a small private write-back, write-allocate cache that lives in a directory-based MSI system. It holds one coherence state and one signed acknowledgement counter for each of a few cache lines. Three input channels feed it, each with valid/ready handshaking. The core channel carries load, store and evict events. The forwarded channel carries forwarded shared and exclusive gets, invalidations and put acknowledgements from the directory. The response channel carries data, with an acknowledgement count, and invalidation acknowledgements. The block emits coherence requests on one output channel and responses to other nodes on a second output channel.

Each line moves between three stable states and eight transient ones. The stable states are I, S and M. The transient states are IS_D, IM_AD, IM_A, SM_AD, SM_A, MI_A, SI_A and II_A. When an input would race with a transaction still in flight, the block holds it back by keeping that channel's ready low, so the message stays at the head of its channel. Exactly one input message is consumed per cycle. Whatever that message causes appears on the registered outputs in the following cycle. The data array, replacement choice and the network are outside the block.

Transitions:
- I→IS_D on a load.
- I→IM_AD and S→SM_AD on a store.
- S→SI_A and M→MI_A on an evict.
- IS_D→S, IM_AD→M|IM_A and SM_AD→M|SM_A on data.
- IM_A→M and SM_A→M on the last invalidation acknowledgement.
- S→I, SM_AD→IM_AD and SI_A→II_A on an invalidation.
- M→S, M→I, MI_A→SI_A and MI_A→II_A on forwarded gets.
- MI_A, SI_A and II_A→I on a put acknowledgement.

Top module: `msi_coh_ctrl`

## Requirements
- R1: While reset is held and after its release, every line is in I, all output valids and the hit flag are 0, and core_ready is 1 when no response or forwarded message is valid.
- R2: A load to a line in I emits GetS (req_kind 0) and enters IS_D. A store in I emits GetM (req_kind 1) and enters IM_AD. A store in S emits GetM and enters SM_AD. Core op codes are: load 0, store 1, evict 2.
- R3: Data (rsp_kind 0) completes IS_D to S. In IM_AD and SM_AD, the incoming ack count is added to the counter. A zero result enters M. A nonzero result enters IM_A or SM_A respectively.
- R4: Each invalidation acknowledgement (rsp_kind 1) decrements the line's counter, including ones that arrive in IM_AD or SM_AD before the data. In IM_A or SM_A, the decrement that brings the counter to zero enters M.
- R5: An invalidation (fwd_kind 2) to a line in IS_D is held with fwd_ready low. A forwarded GetS (fwd_kind 0) or GetM (fwd_kind 1) to a line in IM_AD, IM_A, SM_AD or SM_A is held the same way.
- R6: Loads hit in SM_AD and SM_A. An invalidation in SM_AD emits an invalidation acknowledgement (out_kind 1) to the sender and enters IM_AD, after which loads are held.
- R7: An evict in S emits PutS (req_kind 2) and enters SI_A. An evict in M emits PutM (req_kind 3) and enters MI_A.
- R8: In MI_A, a forwarded GetS emits data (out_kind 0) to the sender with out_to_dir 1 and enters SI_A. A forwarded GetM emits data with out_to_dir 0 and enters II_A.
- R9: In SI_A, an invalidation emits an invalidation acknowledgement and enters II_A. A put acknowledgement (fwd_kind 3) in MI_A, SI_A or II_A enters I.
- R10: In M, a forwarded GetS emits data to the sender and the directory (out_to_dir 1) and enters S. A forwarded GetM emits data to the sender only and enters I.
- R11: Loads hit in S and M, and stores hit in M, with core_hit 1 and no request. Every core event to a line in a transient state other than an SM_AD/SM_A load is held with core_ready low.
- R12: Responses are never held. A valid response takes priority over the other two channels, and an accepted forwarded message takes priority over the core. A forwarded message that is held does not block core events.
- R13: Outputs are registered. A message accepted at one clock edge shows its request or response on the outputs for exactly the following cycle, with out_dest equal to the forwarded message's sender.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core event present |
| core_ready | output | 1 | Core event consumed this cycle |
| core_op | input | 2 | 0 load, 1 store, 2 evict |
| core_line | input | IDX_W | Line index of the core event |
| fwd_valid | input | 1 | Forwarded message present |
| fwd_ready | output | 1 | Forwarded message consumed this cycle |
| fwd_kind | input | 2 | 0 GetS, 1 GetM, 2 invalidation, 3 put ack |
| fwd_line | input | IDX_W | Line index of the forwarded message |
| fwd_src | input | NODE_W | Node that requested the forwarded action |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response consumed this cycle |
| rsp_kind | input | 1 | 0 data, 1 invalidation acknowledgement |
| rsp_line | input | IDX_W | Line index of the response |
| rsp_acks | input | ACK_W | Signed count of acknowledgements to expect (data only) |
| req_valid | output | 1 | Coherence request issued |
| req_kind | output | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| req_line | output | IDX_W | Line index of the request |
| out_valid | output | 1 | Response to another node issued |
| out_kind | output | 1 | 0 data (ack 0), 1 invalidation acknowledgement |
| out_line | output | IDX_W | Line index of the response |
| out_dest | output | NODE_W | Destination node |
| out_to_dir | output | 1 | Also send a copy of the data to the directory |
| core_hit | output | 1 | Previous core event hit |

## Verification
The assertions take a few things for granted about the inputs. Messages for a line arrive only in an order a real directory could produce. A data response appears only while its line waits for data. The net acknowledgement count fits the signed counter. With these inputs, a line waiting only for acknowledgements never holds a zero count. The stimulus is a single scripted protocol walk over four lines that keeps to these conditions. It drives one message per channel per step. The only places it drives two channels at once are the directed priority steps, and there the losing message is chosen so that it can safely wait.

// File: rtl/msi_coh_pkg.sv
package msi_coh_pkg;

    typedef enum logic [3:0] {
        ST_I, ST_IS_D, ST_IM_AD, ST_IM_A, ST_S, ST_SM_AD,
        ST_SM_A, ST_M, ST_MI_A, ST_SI_A, ST_II_A
    } line_st_e;

    typedef enum logic [1:0] {SRC_NONE, SRC_CORE, SRC_FWD, SRC_RSP} ev_src_e;

    typedef enum logic [1:0] {RQ_GETS, RQ_GETM, RQ_PUTS, RQ_PUTM} req_e;

    typedef enum logic {RO_DATA, RO_INVACK} rsp_out_e;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_EVICT = 2'd2;

    localparam logic [1:0] FW_GETS   = 2'd0;
    localparam logic [1:0] FW_GETM   = 2'd1;
    localparam logic [1:0] FW_INV    = 2'd2;
    localparam logic [1:0] FW_PUTACK = 2'd3;

    localparam logic RI_DATA   = 1'b0;
    localparam logic RI_INVACK = 1'b1;

    typedef struct packed {
        logic     req_v;
        req_e     req_t;
        logic     out_v;
        rsp_out_e out_t;
        logic     to_dir;
        logic     hit;
    } action_t;

    // Core events wait in every transient state except a load in SM_AD/SM_A.
    function automatic logic core_held(line_st_e st, logic [1:0] op);
        logic held;
        unique case (st)
            ST_I, ST_S, ST_M:   held = 1'b0;
            ST_SM_AD, ST_SM_A:  held = (op != OP_LOAD);
            default:            held = 1'b1;
        endcase
        return held;
    endfunction

    // Forwarded messages that race an outstanding miss wait at the channel head.
    function automatic logic fwd_held(line_st_e st, logic [1:0] kind);
        logic held;
        unique case (st)
            ST_IS_D:                                held = (kind == FW_INV);
            ST_IM_AD, ST_IM_A, ST_SM_AD, ST_SM_A:   held = (kind == FW_GETS) || (kind == FW_GETM);
            default:                                held = 1'b0;
        endcase
        return held;
    endfunction

endpackage

// File: rtl/msi_coh_line.sv
module msi_coh_line
    import msi_coh_pkg::*;
#(
    parameter int ACK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  ev_src_e                 src,
    input  logic [1:0]              code,
    input  logic signed [ACK_W-1:0] acks,
    output line_st_e                st,
    output action_t                 act
);

    localparam logic signed [ACK_W-1:0] ONE = ACK_W'(1);

    line_st_e                st_nx;
    logic signed [ACK_W-1:0] cnt, cnt_nx, sum, dec;

    assign sum = cnt + acks;
    assign dec = cnt - ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_I;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        act    = '0;
        if (sel) begin
            unique case (src)
                SRC_CORE: begin
                    unique case (st)
                        ST_I: begin
                            if (code == OP_LOAD) begin
                                act.req_v = 1'b1; act.req_t = RQ_GETS; st_nx = ST_IS_D;
                            end else if (code == OP_STORE) begin
                                act.req_v = 1'b1; act.req_t = RQ_GETM; st_nx = ST_IM_AD;
                                cnt_nx = '0;
                            end
                        end
                        ST_S: begin
                            if (code == OP_LOAD) begin
                                act.hit = 1'b1;
                            end else if (code == OP_STORE) begin
                                act.req_v = 1'b1; act.req_t = RQ_GETM; st_nx = ST_SM_AD;
                                cnt_nx = '0;
                            end else if (code == OP_EVICT) begin
                                act.req_v = 1'b1; act.req_t = RQ_PUTS; st_nx = ST_SI_A;
                            end
                        end
                        ST_M: begin
                            if (code == OP_LOAD || code == OP_STORE) begin
                                act.hit = 1'b1;
                            end else if (code == OP_EVICT) begin
                                act.req_v = 1'b1; act.req_t = RQ_PUTM; st_nx = ST_MI_A;
                            end
                        end
                        ST_SM_AD, ST_SM_A: act.hit = (code == OP_LOAD);
                        default: ;
                    endcase
                end
                SRC_FWD: begin
                    unique case (st)
                        ST_S, ST_SM_AD, ST_SI_A: begin
                            if (code == FW_INV) begin
                                act.out_v = 1'b1; act.out_t = RO_INVACK;
                                st_nx = (st == ST_S) ? ST_I : (st == ST_SM_AD) ? ST_IM_AD : ST_II_A;
                            end else if (code == FW_PUTACK && st == ST_SI_A) begin
                                st_nx = ST_I;
                            end
                        end
                        ST_M, ST_MI_A: begin
                            if (code == FW_GETS) begin
                                act.out_v = 1'b1; act.out_t = RO_DATA; act.to_dir = 1'b1;
                                st_nx = (st == ST_M) ? ST_S : ST_SI_A;
                            end else if (code == FW_GETM) begin
                                act.out_v = 1'b1; act.out_t = RO_DATA;
                                st_nx = (st == ST_M) ? ST_I : ST_II_A;
                            end else if (code == FW_PUTACK && st == ST_MI_A) begin
                                st_nx = ST_I;
                            end
                        end
                        ST_II_A: if (code == FW_PUTACK) st_nx = ST_I;
                        default: ;
                    endcase
                end
                SRC_RSP: begin
                    if (code[0] == RI_DATA) begin
                        unique case (st)
                            ST_IS_D: st_nx = ST_S;
                            ST_IM_AD, ST_SM_AD: begin
                                cnt_nx = sum;
                                if (sum == '0) st_nx = ST_M;
                                else           st_nx = (st == ST_IM_AD) ? ST_IM_A : ST_SM_A;
                            end
                            default: ;
                        endcase
                    end else begin
                        unique case (st)
                            ST_IM_AD, ST_SM_AD: cnt_nx = dec;
                            ST_IM_A, ST_SM_A: begin
                                cnt_nx = dec;
                                if (dec == '0) st_nx = ST_M;
                            end
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: a pending load miss only ever completes to S
    p_isd_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IS_D |=> (st == ST_IS_D || st == ST_S));

    // R4: while only acknowledgements are awaited, some are still outstanding
    p_wait_ack_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IM_A || st == ST_SM_A) |-> cnt != '0);

    // R5: the arbiter never hands an invalidation to a line awaiting shared data
    p_inv_held_isd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && src == SRC_FWD && st == ST_IS_D) |-> code != FW_INV);

    // R10: from M a line can only stay, downgrade, lose the line or start eviction
    p_m_exits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_M |=> (st == ST_M || st == ST_S || st == ST_I || st == ST_MI_A));

    // R9: an eviction with no copy left ends only through I
    p_iia_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_II_A |=> (st == ST_II_A || st == ST_I));

endmodule

// File: rtl/msi_coh_ctrl.sv
module msi_coh_ctrl
    import msi_coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NODE_W    = 3,
    parameter int ACK_W     = 4,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    core_valid,
    output logic                    core_ready,
    input  logic [1:0]              core_op,
    input  logic [IDX_W-1:0]        core_line,
    input  logic                    fwd_valid,
    output logic                    fwd_ready,
    input  logic [1:0]              fwd_kind,
    input  logic [IDX_W-1:0]        fwd_line,
    input  logic [NODE_W-1:0]       fwd_src,
    input  logic                    rsp_valid,
    output logic                    rsp_ready,
    input  logic                    rsp_kind,
    input  logic [IDX_W-1:0]        rsp_line,
    input  logic signed [ACK_W-1:0] rsp_acks,
    output logic                    req_valid,
    output logic [1:0]              req_kind,
    output logic [IDX_W-1:0]        req_line,
    output logic                    out_valid,
    output logic                    out_kind,
    output logic [IDX_W-1:0]        out_line,
    output logic [NODE_W-1:0]       out_dest,
    output logic                    out_to_dir,
    output logic                    core_hit
);

    line_st_e                sts  [NUM_LINES];
    action_t                 acts [NUM_LINES];
    logic                    core_fire, fwd_fire, rsp_fire;
    ev_src_e                 ev_src;
    logic [1:0]              ev_code;
    logic [IDX_W-1:0]        ev_line;
    logic signed [ACK_W-1:0] ev_acks;
    action_t                 act_sel;

    // Arbitration: responses always drain, forwarded beats core.
    assign rsp_ready  = 1'b1;
    assign rsp_fire   = rsp_valid;
    assign fwd_ready  = !rsp_valid && !fwd_held(sts[fwd_line], fwd_kind);
    assign fwd_fire   = fwd_valid && fwd_ready;
    assign core_ready = !rsp_valid && !fwd_fire && !core_held(sts[core_line], core_op);
    assign core_fire  = core_valid && core_ready;

    always_comb begin
        ev_src  = SRC_NONE;
        ev_code = '0;
        ev_line = '0;
        ev_acks = '0;
        if (rsp_fire) begin
            ev_src = SRC_RSP; ev_code = {1'b0, rsp_kind}; ev_line = rsp_line; ev_acks = rsp_acks;
        end else if (fwd_fire) begin
            ev_src = SRC_FWD; ev_code = fwd_kind; ev_line = fwd_line;
        end else if (core_fire) begin
            ev_src = SRC_CORE; ev_code = core_op; ev_line = core_line;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        msi_coh_line #(.ACK_W(ACK_W)) u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .sel  ((ev_src != SRC_NONE) && (ev_line == IDX_W'(i))),
            .src  (ev_src),
            .code (ev_code),
            .acks (ev_acks),
            .st   (sts[i]),
            .act  (acts[i])
        );
    end

    assign act_sel = acts[ev_line];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_kind   <= '0;
            req_line   <= '0;
            out_valid  <= 1'b0;
            out_kind   <= 1'b0;
            out_line   <= '0;
            out_dest   <= '0;
            out_to_dir <= 1'b0;
            core_hit   <= 1'b0;
        end else begin
            req_valid  <= act_sel.req_v;
            req_kind   <= act_sel.req_v ? act_sel.req_t : 2'd0;
            req_line   <= act_sel.req_v ? ev_line : '0;
            out_valid  <= act_sel.out_v;
            out_kind   <= act_sel.out_v ? act_sel.out_t : 1'b0;
            out_line   <= act_sel.out_v ? ev_line : '0;
            out_dest   <= act_sel.out_v ? fwd_src : '0;
            out_to_dir <= act_sel.out_v && act_sel.to_dir;
            core_hit   <= act_sel.hit;
        end
    end

    // R13: every request is the echo of a core event one cycle earlier
    p_req_after_core_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(core_fire));

    // R13: every outgoing response follows an accepted forwarded message
    p_out_after_fwd_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fwd_fire));

    // R12: a valid response blocks the other two channels that cycle
    p_rsp_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!core_fire && !fwd_fire));

    // R10: the directory copy is only ever attached to data
    p_dir_copy_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_to_dir) |-> out_kind == RO_DATA);

    // R11: a hit never also issues a request
    p_hit_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        core_hit |-> !req_valid);

endmodule

// File: tb/msi_coh_ctrl_test.sv
module msi_coh_ctrl_test;

    typedef struct packed {
        logic [1:0] ch;     // 0 core, 1 forwarded, 2 response
        logic [1:0] code;
        logic [1:0] line;
        logic [3:0] arg;    // sender id or signed ack count
        logic       rdy;
        logic       rv;
        logic [1:0] rt;
        logic       ov;
        logic       ot;
        logic       od;
        logic       hit;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VT [NV] = '{
        '{2'd0,2'd0,2'd0,4'd0, 1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2 load I -> GetS
        '{2'd0,2'd0,2'd0,4'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11}, // R11 held in IS_D
        '{2'd1,2'd2,2'd0,4'd5, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 inv held in IS_D
        '{2'd2,2'd0,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 data -> S
        '{2'd0,2'd0,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd11}, // R11 load hit S
        '{2'd0,2'd1,2'd0,4'd0, 1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2 store S -> GetM
        '{2'd0,2'd0,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 hit SM_AD
        '{2'd1,2'd0,2'd0,4'd3, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 fwd GetS held
        '{2'd2,2'd1,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 early ack -> -1
        '{2'd2,2'd0,2'd0,4'd2, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 data ack2 -> SM_A
        '{2'd0,2'd0,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 hit SM_A
        '{2'd0,2'd1,2'd0,4'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11}, // R11 store held
        '{2'd2,2'd1,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 last ack -> M
        '{2'd0,2'd1,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd11}, // R11 store hit M
        '{2'd1,2'd0,2'd0,4'd3, 1'b1,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0, 4'd10}, // R10 M fwd GetS
        '{2'd0,2'd0,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10 now S
        '{2'd0,2'd2,2'd0,4'd0, 1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 evict S PutS
        '{2'd0,2'd0,2'd0,4'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11}, // R11 held SI_A
        '{2'd1,2'd2,2'd0,4'd2, 1'b1,1'b0,2'd0,1'b1,1'b1,1'b0,1'b0, 4'd9},  // R9 SI_A inv
        '{2'd1,2'd3,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9 put ack II_A
        '{2'd0,2'd0,2'd0,4'd0, 1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9 back in I
        '{2'd2,2'd0,2'd0,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
        '{2'd0,2'd1,2'd1,4'd0, 1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2 store I GetM
        '{2'd1,2'd1,2'd1,4'd4, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 GetM held IM_AD
        '{2'd2,2'd0,2'd1,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 -> M
        '{2'd0,2'd2,2'd1,4'd0, 1'b1,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 evict M PutM
        '{2'd1,2'd0,2'd1,4'd4, 1'b1,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0, 4'd8},  // R8 MI_A GetS
        '{2'd1,2'd2,2'd1,4'd4, 1'b1,1'b0,2'd0,1'b1,1'b1,1'b0,1'b0, 4'd9},  // R9 SI_A inv
        '{2'd1,2'd3,2'd1,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
        '{2'd0,2'd1,2'd1,4'd0, 1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2
        '{2'd2,2'd0,2'd1,4'd1, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 ack1 -> IM_A
        '{2'd0,2'd0,2'd1,4'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11}, // R11 held IM_A
        '{2'd2,2'd1,2'd1,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 -> M
        '{2'd0,2'd2,2'd1,4'd0, 1'b1,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
        '{2'd1,2'd1,2'd1,4'd6, 1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd8},  // R8 MI_A GetM
        '{2'd0,2'd0,2'd1,4'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11}, // R11 held II_A
        '{2'd1,2'd3,2'd1,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
        '{2'd0,2'd0,2'd2,4'd0, 1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2
        '{2'd2,2'd0,2'd2,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
        '{2'd0,2'd1,2'd2,4'd0, 1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2 -> SM_AD
        '{2'd1,2'd2,2'd2,4'd6, 1'b1,1'b0,2'd0,1'b1,1'b1,1'b0,1'b0, 4'd6},  // R6 inv SM_AD
        '{2'd0,2'd0,2'd2,4'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6 load held
        '{2'd2,2'd0,2'd2,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 -> M
        '{2'd1,2'd1,2'd2,4'd1, 1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd10}, // R10 M GetM
        '{2'd0,2'd0,2'd2,4'd0, 1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10 now I
        '{2'd0,2'd1,2'd3,4'd0, 1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2
        '{2'd2,2'd0,2'd3,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
        '{2'd0,2'd0,2'd3,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd11}, // R11 load hit M
        '{2'd0,2'd2,2'd3,4'd0, 1'b1,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
        '{2'd1,2'd3,2'd3,4'd0, 1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9 put ack MI_A
        '{2'd0,2'd0,2'd3,4'd0, 1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd9}   // R9 back in I
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_valid = 1'b0, fwd_valid = 1'b0, rsp_valid = 1'b0;
    logic [1:0] core_op = '0, fwd_kind = '0;
    logic [1:0] core_line = '0, fwd_line = '0, rsp_line = '0;
    logic [2:0] fwd_src = '0;
    logic rsp_kind = 1'b0;
    logic signed [3:0] rsp_acks = '0;
    logic core_ready, fwd_ready, rsp_ready;
    logic req_valid, out_valid, out_kind, out_to_dir, core_hit;
    logic [1:0] req_kind, req_line, out_line;
    logic [2:0] out_dest;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msi_coh_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op), .core_line(core_line),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_kind(fwd_kind), .fwd_line(fwd_line),
        .fwd_src(fwd_src),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_line(rsp_line),
        .rsp_acks(rsp_acks),
        .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
        .out_valid(out_valid), .out_kind(out_kind), .out_line(out_line), .out_dest(out_dest),
        .out_to_dir(out_to_dir), .core_hit(core_hit)
    );

    task automatic chk(input logic ok, input int tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic clear_inputs();
        core_valid = 1'b0; fwd_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    task automatic check_outputs(input int tag, input logic rv, input logic [1:0] rt,
                                 input logic [1:0] rl, input logic ov, input logic ot,
                                 input logic od, input logic [2:0] dst, input logic hit);
        chk({req_valid, req_kind} == {rv, rt}, tag, "request", int'({req_valid, req_kind}), int'({rv, rt}));
        chk(!rv || req_line == rl, tag, "request line", int'(req_line), int'(rl));
        chk({out_valid, out_kind, out_to_dir, out_dest} == {ov, ot, od, dst}, tag, "response",
            int'({out_valid, out_kind, out_to_dir, out_dest}), int'({ov, ot, od, dst}));
        chk(!ov || out_line == rl, tag, "response line", int'(out_line), int'(rl));
        chk(core_hit == hit, tag, "hit", int'(core_hit), int'(hit));
    endtask

    task automatic run_vec(input vec_t v);
        logic got;
        @(negedge clk);
        case (v.ch)
            2'd0: begin core_valid = 1'b1; core_op = v.code; core_line = v.line; end
            2'd1: begin fwd_valid = 1'b1; fwd_kind = v.code; fwd_line = v.line; fwd_src = v.arg[2:0]; end
            default: begin rsp_valid = 1'b1; rsp_kind = v.code[0]; rsp_line = v.line; rsp_acks = v.arg; end
        endcase
        #1;
        got = (v.ch == 2'd0) ? core_ready : (v.ch == 2'd1) ? fwd_ready : rsp_ready;
        chk(got == v.rdy, int'(v.tag), "ready", int'(got), int'(v.rdy));
        @(negedge clk);
        clear_inputs();
        check_outputs(int'(v.tag), v.rv, v.rt, v.line, v.ov, v.ot, v.od,
                      v.ov ? v.arg[2:0] : 3'd0, v.hit);
    endtask

    initial begin
        #(8 * 100000);
        chk(1'b0, 0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_outputs(1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_ready == 1'b1, 1, "core_ready after reset", int'(core_ready), 1);
        check_outputs(1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R12: response beats a core load hit on line 0 (S); line 2 waits in IS_D
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = 1'b0; rsp_line = 2'd2; rsp_acks = 4'sd0;
        core_valid = 1'b1; core_op = 2'd0; core_line = 2'd0;
        #1;
        chk(rsp_ready == 1'b1, 12, "rsp_ready with core", int'(rsp_ready), 1);
        chk(core_ready == 1'b0, 12, "core_ready behind rsp", int'(core_ready), 0);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(core_hit == 1'b0, 12, "no hit while rsp wins", int'(core_hit), 0);
        // R12: accepted forwarded invalidation beats the core
        fwd_valid = 1'b1; fwd_kind = 2'd2; fwd_line = 2'd0; fwd_src = 3'd7;
        core_line = 2'd1;
        #1;
        chk(fwd_ready == 1'b1, 12, "fwd_ready", int'(fwd_ready), 1);
        chk(core_ready == 1'b0, 12, "core_ready behind fwd", int'(core_ready), 0);
        @(negedge clk);
        fwd_valid = 1'b0; core_valid = 1'b0;
        check_outputs(13, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 3'd7, 1'b0);
        // R13: the response is a single-cycle pulse
        @(negedge clk);
        check_outputs(13, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        // R12: a held invalidation (line 3 in IS_D) does not block the core
        fwd_valid = 1'b1; fwd_kind = 2'd2; fwd_line = 2'd3; fwd_src = 3'd1;
        core_valid = 1'b1; core_op = 2'd0; core_line = 2'd0;
        #1;
        chk(fwd_ready == 1'b0, 12, "fwd held", int'(fwd_ready), 0);
        chk(core_ready == 1'b1, 12, "core passes held fwd", int'(core_ready), 1);
        @(negedge clk);
        clear_inputs();
        check_outputs(12, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule